// File: doc/BRIEF.md
# Codec Clock-Mode and Power-Down Controller

This block decides the operating state of a PCM voice codec from two dual-use control pins, looking at them with a fast, free-running system clock. A pin that keeps toggling is treated as a clock. A pin that holds one level is treated as a logic control. From this the block derives one of three states: power-down, synchronous, or asynchronous. It also tells the receive path which master clock and which bit clock to use, and which master-clock division ratio applies.

The receive-master-clock pin acts as follows. Held high, it powers the codec down. Held low, it powers the codec up, and the transmit master clock drives everything, which is synchronous operation. Toggling, it is the separate receive master clock, which is asynchronous operation. The receive-bit-clock pin works the same way. When it holds a static level, that level selects 2.048 MHz or 1.536/1.544 MHz master-clock operation, and the transmit bit clock serves both directions. Frame-sync activity keeps the codec awake. If no frame sync rises for a programmable time of about 2 ms, the codec powers down.

The block also generates a 256 kHz filter-clock enable from the selected master clock. In 2.048 MHz operation it divides by 8. In 1.536 MHz operation it divides by 6. A frame counter, restarted by every transmit frame-sync rise, drops the 193rd master-clock edge of a frame, so a 1.544 MHz clock gives the same rate as 1.536 MHz.

Top module: `codec_clkctl`

## Requirements
- R1: After reset, `pdn_o`=1 and `hiz_o`=1, `sync_o`=`async_o`=0, and `filt_en_o`=0.
- R2: While the receive-master-clock pin is confirmed static high, `pdn_o`=1, `hiz_o`=1, both mode flags are 0, and `filt_en_o` stays 0.
- R3: With that pin confirmed static low and frame syncs rising, `sync_o`=1, `pdn_o`=0, `hiz_o`=0 and `rx_mclk_sel_o`=0 (transmit master clock). With no frame sync since reset, the block stays in power-down.
- R4: With that pin toggling and frame syncs present, `async_o`=1, `sync_o`=0 and `rx_mclk_sel_o`=1. The filter enable is then derived from that pin.
- R5: `pdn_o` rises exactly `PDN_CYC` cycles after the last rising edge on either frame-sync input, and not earlier.
- R6: When `div8_o`=0 and a frame holds 193 master-clock rising edges, the 193rd edge of the frame is not counted. This gives 32 enable pulses per frame.
- R7: `filt_en_o` pulses once per 8 counted master-clock rising edges when `div8_o`=1, and once per 6 when `div8_o`=0. It is never high in two consecutive cycles.
- R8: With the receive-bit-clock pin static, `rx_bclk_sel_o`=0, and `div8_o` equals the pin level (1 = 2.048 MHz, 0 = 1.536/1.544 MHz).
- R9: With the receive-bit-clock pin toggling, `rx_bclk_sel_o`=1 and `div8_o` equals parameter `CLOCKED_IS_2048`.
- R10: A pin counts as toggling once two edges fall within `WIN_CYC` system cycles of each other. It counts as static, at its current level, after `WIN_CYC` cycles with no edge.
- R11: A master-clock edge that falls in the same cycle as a transmit frame-sync rise counts as edge 1 of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_x_i | input | 1 | Transmit master clock pin |
| rmclk_pdn_i | input | 1 | Receive master clock or power-down control pin |
| rbclk_sel_i | input | 1 | Receive bit clock or rate-select pin |
| fs_x_i | input | 1 | Transmit frame sync |
| fs_r_i | input | 1 | Receive frame sync |
| pdn_o | output | 1 | Codec powered down |
| sync_o | output | 1 | Synchronous mode active |
| async_o | output | 1 | Asynchronous mode active |
| rx_mclk_sel_o | output | 1 | 1: receive uses its own master clock; 0: transmit master clock |
| rx_bclk_sel_o | output | 1 | 1: receive uses its own bit clock; 0: transmit bit clock |
| div8_o | output | 1 | 1: divide by 8 (2.048 MHz); 0: divide by 6 |
| hiz_o | output | 1 | Data output and receive analog output held in high impedance |
| filt_en_o | output | 1 | One-cycle 256 kHz filter-clock enable |

## Verification
Two functions can act on the same system cycle: the frame-counter restart caused by a transmit frame-sync rise, and the dropping of the 193rd master-clock edge. The bench provokes this by placing the frame-sync rise on exactly the same cycle as a master-clock rise, with 193 edges per frame. If that edge opens the new frame, the 193rd edge is still dropped and every frame yields 32 enables. If the restart lost that edge, nothing would be dropped and the pulse count over ten frames would exceed 320. The bench judges the result by counting enables over a window of exactly ten frames, which makes the count independent of phase.

// File: rtl/codec_clkctl_pkg.sv
// Shared types for the codec clock-mode controller.
// Assumes: nothing beyond IEEE 1800-2017.
package codec_clkctl_pkg;
    typedef enum logic [1:0] {
        ST_PDN   = 2'd0,
        ST_SYNC  = 2'd1,
        ST_ASYNC = 2'd2
    } op_state_t;

    localparam int PIN_RMCLK = 0;
    localparam int PIN_RBCLK = 1;
    localparam int NUM_DUAL  = 2;
endpackage

// File: rtl/cc_sync.sv
// Two-flop synchronizer for a bus of independent asynchronous pins.
// Assumes: each bit is an unrelated slow signal; reset value is zero.
module cc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta;

    // Two-stage capture of the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q_o  <= '0;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end
endmodule

// File: rtl/cc_activity.sv
// Classifies one synchronized pin as toggling (used as a clock) or static
// (used as a level). Toggling: two edges no more than WIN_CYC cycles apart.
// Static: WIN_CYC cycles with no edge; the level is then captured.
// Assumes: pin already synchronized to clk.
module cc_activity #(
    parameter int   WIN_CYC = 524,
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    output logic tog_o,
    output logic lvl_o
);
    localparam int CW = $clog2(WIN_CYC + 1);

    logic          prev;
    logic          seen;
    logic [CW-1:0] quiet;
    logic          edg;

    assign edg = pin_s ^ prev;

    // Edge spacing measurement and toggling/static decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev  <= 1'b0;
            seen  <= 1'b0;
            quiet <= '0;
            tog_o <= 1'b0;
            lvl_o <= RST_LVL;
        end else begin
            prev <= pin_s;
            if (edg) begin
                quiet <= '0;
                seen  <= 1'b1;
                if (seen && (quiet < CW'(WIN_CYC)))
                    tog_o <= 1'b1;
            end else if (quiet != CW'(WIN_CYC)) begin
                quiet <= quiet + 1'b1;
                if (quiet == CW'(WIN_CYC - 1)) begin
                    tog_o <= 1'b0;
                    seen  <= 1'b0;
                    lvl_o <= pin_s;
                end
            end
        end
    end

    // R10: toggling is dropped only after a full quiet window
    p_static_after_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tog_o) |-> ($past(quiet) == CW'(WIN_CYC - 1)) && !$past(edg));

    // R10: the captured level only moves when the pin is judged static
    p_level_when_static_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_o) |-> !tog_o);
endmodule

// File: rtl/cc_mode.sv
// Derives operating state, clock selections and divider ratio from the
// classified dual-use pins and frame-sync activity. A rising edge on either
// frame sync restarts a PDN_CYC-cycle keep-alive timer.
// Assumes: inputs synchronized to clk.
module cc_mode
    import codec_clkctl_pkg::*;
#(
    parameter int   PDN_CYC         = 65536,
    parameter logic CLOCKED_IS_2048 = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rm_tog,
    input  logic rm_lvl,
    input  logic bc_tog,
    input  logic bc_lvl,
    input  logic fsx_s,
    input  logic fsr_s,
    output logic pdn_o,
    output logic sync_o,
    output logic async_o,
    output logic rx_mclk_sel_o,
    output logic rx_bclk_sel_o,
    output logic div8_o,
    output logic fsx_rise_o
);
    localparam int TW = $clog2(PDN_CYC + 1);

    logic          fsx_d, fsr_d;
    logic          alive;
    logic [TW-1:0] tmr;
    logic          fs_rise;
    op_state_t     st;

    assign fsx_rise_o = fsx_s & ~fsx_d;
    assign fs_rise    = fsx_rise_o | (fsr_s & ~fsr_d);

    // Keep-alive timer restarted by any frame-sync rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsx_d <= 1'b0;
            fsr_d <= 1'b0;
            alive <= 1'b0;
            tmr   <= '0;
        end else begin
            fsx_d <= fsx_s;
            fsr_d <= fsr_s;
            if (fs_rise) begin
                tmr   <= '0;
                alive <= 1'b1;
            end else if (alive) begin
                if (tmr == TW'(PDN_CYC - 1))
                    alive <= 1'b0;
                else
                    tmr <= tmr + 1'b1;
            end
        end
    end

    // Operating state from pin classification and keep-alive.
    always_comb begin
        if ((!rm_tog && rm_lvl) || !alive)
            st = ST_PDN;
        else if (rm_tog)
            st = ST_ASYNC;
        else
            st = ST_SYNC;
    end

    assign pdn_o         = (st == ST_PDN);
    assign sync_o        = (st == ST_SYNC);
    assign async_o       = (st == ST_ASYNC);
    assign rx_mclk_sel_o = rm_tog;
    assign rx_bclk_sel_o = bc_tog;
    assign div8_o        = bc_tog ? CLOCKED_IS_2048 : bc_lvl;

    // R5: the keep-alive lapses only after exactly PDN_CYC idle cycles
    p_timeout_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alive) |-> ($past(tmr) == TW'(PDN_CYC - 1)) && !$past(fs_rise));

    // R3: waking needs a frame-sync rise or a pin that left the high level
    p_wake_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pdn_o) |-> $past(fs_rise) || $past(rm_lvl != 1'b0 && !rm_tog));
endmodule

// File: rtl/cc_fclk.sv
// Produces the one-cycle filter-clock enable from the selected master clock:
// one pulse per DIV_FAST or DIV_SLOW counted rising edges. In slow ratio the
// FRAME_EDGES-th edge after a transmit frame-sync rise is dropped.
// Assumes: master clock synchronized, at most one edge per clk cycle.
module cc_fclk #(
    parameter int FRAME_EDGES = 193,
    parameter int DIV_FAST    = 8,
    parameter int DIV_SLOW    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_s,
    input  logic fs_rise,
    input  logic div8,
    input  logic run,
    output logic filt_en_o
);
    localparam int FCW = $clog2(FRAME_EDGES + 1) + 1;
    localparam int DCW = $clog2(DIV_FAST);

    logic           mprev;
    logic           edg;
    logic           absorb;
    logic [FCW-1:0] fcnt;
    logic [DCW-1:0] dcnt;
    logic [DCW-1:0] lim;

    assign edg    = mclk_s & ~mprev;
    assign lim    = div8 ? DCW'(DIV_FAST - 1) : DCW'(DIV_SLOW - 1);
    assign absorb = edg && !div8 && !fs_rise && (fcnt == FCW'(FRAME_EDGES - 1));

    // Master-edge count within the frame, restarted by frame sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mprev <= 1'b0;
            fcnt  <= '0;
        end else begin
            mprev <= mclk_s;
            if (fs_rise)
                fcnt <= edg ? FCW'(1) : '0;
            else if (edg && fcnt != '1)
                fcnt <= fcnt + 1'b1;
        end
    end

    // Ratio divider producing the enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dcnt      <= '0;
            filt_en_o <= 1'b0;
        end else begin
            filt_en_o <= 1'b0;
            if (edg && !absorb) begin
                if (dcnt >= lim) begin
                    dcnt      <= '0;
                    filt_en_o <= 1'b1;
                end else begin
                    dcnt <= dcnt + 1'b1;
                end
            end
        end
    end

    // R7: enables are isolated single-cycle pulses
    p_no_back2back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        filt_en_o |=> !filt_en_o);

    // R2: nothing comes out while powered down
    p_quiet_in_pdn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !filt_en_o);

    // R11: a frame-sync rise leaves the frame count at 0 or 1
    p_resync_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fs_rise) |-> fcnt <= FCW'(1));

    // R6: a dropped edge leaves the divider untouched
    p_absorb_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && absorb) |=> !filt_en_o && $stable(dcnt));
endmodule

// File: rtl/codec_clkctl.sv
// Top of the codec clock-mode and power-down controller. Synchronizes the
// pins, classifies the two dual-use pins, derives the operating state and
// builds the 256 kHz filter-clock enable from the selected master clock.
// Assumes: clk is much faster than every pin (several cycles per pin phase).
module codec_clkctl
    import codec_clkctl_pkg::*;
#(
    parameter int   WIN_CYC         = 524,
    parameter int   PDN_CYC         = 65536,
    parameter int   FRAME_EDGES     = 193,
    parameter int   DIV_FAST        = 8,
    parameter int   DIV_SLOW        = 6,
    parameter logic CLOCKED_IS_2048 = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_x_i,
    input  logic rmclk_pdn_i,
    input  logic rbclk_sel_i,
    input  logic fs_x_i,
    input  logic fs_r_i,
    output logic pdn_o,
    output logic sync_o,
    output logic async_o,
    output logic rx_mclk_sel_o,
    output logic rx_bclk_sel_o,
    output logic div8_o,
    output logic hiz_o,
    output logic filt_en_o
);
    localparam int NPIN = 5;

    logic [NPIN-1:0]     raw, syn;
    logic [NUM_DUAL-1:0] dual_s, dual_tog, dual_lvl;
    logic                fsx_rise;
    logic                mclk_sel_s;

    assign raw = {fs_r_i, fs_x_i, mclk_x_i, rbclk_sel_i, rmclk_pdn_i};

    cc_sync #(.W(NPIN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw),
        .q_o  (syn)
    );

    assign dual_s = syn[NUM_DUAL-1:0];

    for (genvar g = 0; g < NUM_DUAL; g++) begin : g_dual
        cc_activity #(.WIN_CYC(WIN_CYC), .RST_LVL(1'b1)) u_act (
            .clk  (clk),
            .rst_n(rst_n),
            .pin_s(dual_s[g]),
            .tog_o(dual_tog[g]),
            .lvl_o(dual_lvl[g])
        );
    end

    cc_mode #(.PDN_CYC(PDN_CYC), .CLOCKED_IS_2048(CLOCKED_IS_2048)) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .rm_tog       (dual_tog[PIN_RMCLK]),
        .rm_lvl       (dual_lvl[PIN_RMCLK]),
        .bc_tog       (dual_tog[PIN_RBCLK]),
        .bc_lvl       (dual_lvl[PIN_RBCLK]),
        .fsx_s        (syn[3]),
        .fsr_s        (syn[4]),
        .pdn_o        (pdn_o),
        .sync_o       (sync_o),
        .async_o      (async_o),
        .rx_mclk_sel_o(rx_mclk_sel_o),
        .rx_bclk_sel_o(rx_bclk_sel_o),
        .div8_o       (div8_o),
        .fsx_rise_o   (fsx_rise)
    );

    // Receive master clock: own pin in asynchronous mode, else transmit one.
    assign mclk_sel_s = rx_mclk_sel_o ? syn[PIN_RMCLK] : syn[2];
    assign hiz_o      = pdn_o;

    cc_fclk #(.FRAME_EDGES(FRAME_EDGES), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_fclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .mclk_s   (mclk_sel_s),
        .fs_rise  (fsx_rise),
        .div8     (div8_o),
        .run      (!pdn_o),
        .filt_en_o(filt_en_o)
    );

    // R8: a static rate pin keeps the transmit bit clock on both paths
    p_static_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_bclk_sel_o |-> div8_o == dual_lvl[PIN_RBCLK]);
endmodule

// File: tb/sim_codec_clkctl.sv
module sim_codec_clkctl;
    localparam int CLK_PER = 10;
    localparam int WIN     = 16;
    localparam int PDN     = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk_x = 1'b0, rmclk = 1'b0, rbclk = 1'b0, fs_x = 1'b0, fs_r = 1'b0;
    logic pdn, sync_m, async_m, mcsel, bcsel, div8, hiz, fen;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Stimulus modes: 0 static low, 1 static high, 2 toggling.
    int rm_mode = 0;
    int bc_mode = 0;
    int fs_on = 0;
    int frame_e = 193;
    int fs_ph = 0;
    int p = 0;

    always #(CLK_PER/2) clk = ~clk;

    codec_clkctl #(.WIN_CYC(WIN), .PDN_CYC(PDN)) u0 (
        .clk(clk), .rst_n(rst_n), .mclk_x_i(mclk_x), .rmclk_pdn_i(rmclk),
        .rbclk_sel_i(rbclk), .fs_x_i(fs_x), .fs_r_i(fs_r),
        .pdn_o(pdn), .sync_o(sync_m), .async_o(async_m),
        .rx_mclk_sel_o(mcsel), .rx_bclk_sel_o(bcsel), .div8_o(div8),
        .hiz_o(hiz), .filt_en_o(fen)
    );

    // Pin waveform generator: master clock period 4 cycles, frame 4*frame_e.
    always @(negedge clk) begin
        int fl;
        int q;
        fl = 4 * frame_e;
        p <= p + 1;
        mclk_x <= ((p % 4) >= 2);
        rmclk  <= (rm_mode == 2) ? ((p % 4) >= 2) : (rm_mode == 1);
        rbclk  <= (bc_mode == 2) ? ((p % 8) >= 4) : (bc_mode == 1);
        q = (p + fl - fs_ph) % fl;
        fs_x   <= (fs_on != 0) && (q < 4);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_en(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fen) cnt++;
        end
    endtask

    initial begin
        int c;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 reset state
        chk("R1 pdn", pdn, 1);
        chk("R1 hiz", hiz, 1);
        chk("R1 modes", sync_m + async_m, 0);
        chk("R1 filt_en", fen, 0);

        // R3: pin low but no frame sync yet -> still down
        wait_cyc(100);
        chk("R3 no sync stays pdn", pdn, 1);

        // R3/R8/R6: synchronous, 1.544 MHz
        fs_on = 1;
        wait_cyc(2 * 4 * 193);
        chk("R3 sync", sync_m, 1);
        chk("R3 async", async_m, 0);
        chk("R3 pdn", pdn, 0);
        chk("R3 hiz", hiz, 0);
        chk("R3 mclk sel", mcsel, 0);
        chk("R8 bclk sel", bcsel, 0);
        chk("R8 div8 low", div8, 0);
        count_en(10 * 4 * 193, c);
        chk("R6 1.544 pulses", c, 320);

        // R7: 1.536 MHz divide by 6
        frame_e = 192;
        wait_cyc(3 * 4 * 193);
        count_en(10 * 4 * 192, c);
        chk("R7 div6 pulses", c, 320);

        // R8/R7: static high rate pin, 2.048 MHz divide by 8
        bc_mode = 1;
        frame_e = 256;
        wait_cyc(3 * 4 * 256);
        chk("R8 div8 high", div8, 1);
        count_en(10 * 4 * 256, c);
        chk("R7 div8 pulses", c, 320);

        // R11: frame-sync rise on the same cycle as a master edge
        bc_mode = 0;
        frame_e = 193;
        fs_ph = 2;
        wait_cyc(3 * 4 * 193);
        count_en(10 * 4 * 193, c);
        chk("R11 coincident pulses", c, 320);
        fs_ph = 0;

        // R9: toggling rate pin
        bc_mode = 2;
        wait_cyc(4 * WIN);
        chk("R9 bclk sel", bcsel, 1);
        chk("R9 div8 clocked", div8, 1);
        // R10: back to static after quiet window
        bc_mode = 0;
        wait_cyc(4 * WIN);
        chk("R10 static again", bcsel, 0);
        chk("R10 level captured", div8, 0);

        // R4: asynchronous mode
        rm_mode = 2;
        wait_cyc(3 * 4 * 193);
        chk("R4 async", async_m, 1);
        chk("R4 sync", sync_m, 0);
        chk("R4 mclk sel", mcsel, 1);
        count_en(10 * 4 * 193, c);
        chk("R4 async pulses", c, 320);

        // R2: static high forces power-down
        rm_mode = 1;
        wait_cyc(4 * WIN);
        chk("R2 pdn", pdn, 1);
        chk("R2 hiz", hiz, 1);
        chk("R2 modes", sync_m + async_m, 0);
        count_en(200, c);
        chk("R2 no enables", c, 0);

        // R5: frame-sync timeout
        rm_mode = 0;
        wait_cyc(4 * WIN);
        chk("R5 awake", pdn, 0);
        fs_on = 0;
        wait_cyc(PDN + 4 * 193 + 100);
        chk("R5 timed out", pdn, 1);
        fs_r = 1'b1;
        wait_cyc(3);
        fs_r = 1'b0;
        wait_cyc(PDN - 30);
        chk("R5 before expiry", pdn, 0);
        chk("R5 sync via fs_r", sync_m, 1);
        wait_cyc(60);
        chk("R5 after expiry", pdn, 1);

        done = 1;
    end

    initial begin
        fork
            wait (done == 1);
            begin
                repeat (190000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule